// File: doc/BRIEF.md
# AHB-Lite Burst Address Generator

This block is the address-phase engine of a single AHB-Lite requester. A start request supplies a first address, a transfer size, a burst code, a write flag and, for the open-ended incrementing burst, a beat count. The block then drives the address, transfer type, size and burst code for each beat. It waits whenever the slave holds HREADY low, and it can insert BUSY cycles between beats when the requester is not ready to continue.

Incrementing bursts step by the transfer size. Wrapping bursts stay inside an aligned window whose width is the transfer size times the beat count. An open-ended incrementing burst is never allowed to run across a 1 KB address boundary: the beat that lands on the boundary is issued as a fresh NONSEQ. If the slave signals an error during a data phase, the rest of the burst is dropped. When the final beat's data phase completes normally, a one-cycle done pulse is raised.

Top module: `ahb_burst_agen`

## Requirements
- R1: After reset, and whenever no burst is active, htrans_o is IDLE (2'b00), active_o is low and done_o is low.
- R2: A start_i sampled while active_o is low is accepted. In the next cycle htrans_o is NONSEQ (2'b10), haddr_o equals the sampled start address, hburst_o equals the burst code and hwrite_o equals the write flag. A start_i sampled while active_o is high has no effect on the running burst.
- R3: Every later beat is SEQ (2'b11). For incrementing bursts its address is the previous beat's address plus 2^hsize bytes. Beat counts by burst code: 3'b000 single = 1, 3'b001 open-ended = start_len_i (0 counts as 1), 3'b010 wrap = 4, 3'b011 incr = 4, 3'b100 wrap = 8, 3'b101 incr = 8, 3'b110 wrap = 16, 3'b111 incr = 16.
- R4: In a wrapping burst, addresses stay inside the aligned window of 2^hsize × beats bytes. They wrap to the window base after its top (4-byte beats of a 4-beat wrap from 0x34 give 0x34, 0x38, 0x3C, 0x30).
- R5: hsize_o equals the requested size clamped to 2 (the 32-bit data bus width), and it does not change while a burst is active.
- R6: In a cycle where HREADY is low and a NONSEQ, SEQ or BUSY is on the bus, haddr_o, htrans_o, hsize_o, hburst_o and hwrite_o keep their values into the next cycle.
- R7: If busy_req_i is high when a non-final beat is accepted, the next cycle shows BUSY (2'b01) with the next beat's address. BUSY is kept while busy_req_i stays high at each HREADY-high edge. busy_req_i has no effect when the final beat is accepted.
- R8: In an open-ended incrementing burst (3'b001), a beat whose address is a multiple of 1024 is issued as NONSEQ instead of SEQ.
- R9: hresp_i high during a data phase makes htrans_o IDLE and active_o low in the next cycle. The remaining beats are dropped and no done pulse follows.
- R10: done_o pulses high for exactly one cycle, in the cycle after the final beat's data phase completes with HREADY high. active_o is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Request a new burst |
| start_addr_i | input | ADDR_W | First beat address |
| start_size_i | input | 3 | Transfer size, log2 of bytes |
| start_burst_i | input | 3 | Burst code |
| start_len_i | input | LEN_W | Beat count for open-ended bursts |
| start_write_i | input | 1 | Direction, 1 = write |
| busy_req_i | input | 1 | Ask for BUSY before the next beat |
| hready_i | input | 1 | Slave ready / phase complete |
| hresp_i | input | 1 | Slave error response |
| haddr_o | output | ADDR_W | Beat address |
| htrans_o | output | 2 | Transfer type |
| hsize_o | output | 3 | Transfer size |
| hburst_o | output | 3 | Burst code |
| hwrite_o | output | 1 | Direction |
| active_o | output | 1 | A burst is in progress |
| done_o | output | 1 | Final data phase completed |

## Verification
The assertions assume that start addresses are aligned to the transfer size. They also assume that fixed-length incrementing bursts are requested so that they fit inside one 1 KB block, and that an error response arrives with HREADY low in its first cycle, as in a two-cycle error. The random stimulus aligns every start address to the clamped size and pulls fixed-length incrementing starts back inside their 1 KB block. It deliberately places open-ended bursts just below a boundary. Error responses are only driven in the directed case, in the two-cycle form.

// File: rtl/ahb_agen_pkg.sv
package ahb_agen_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic [2:0] BU_SINGLE = 3'd0;
  localparam logic [2:0] BU_INCR   = 3'd1;
  localparam logic [2:0] BU_WRAP4  = 3'd2;
  localparam logic [2:0] BU_INCR4  = 3'd3;
  localparam logic [2:0] BU_WRAP8  = 3'd4;
  localparam logic [2:0] BU_INCR8  = 3'd5;
  localparam logic [2:0] BU_WRAP16 = 3'd6;
  localparam logic [2:0] BU_INCR16 = 3'd7;

  function automatic logic is_wrap(input logic [2:0] b);
    return (b == BU_WRAP4) || (b == BU_WRAP8) || (b == BU_WRAP16);
  endfunction

  // log2 of the beat count of a wrapping burst
  function automatic logic [2:0] wrap_shift(input logic [2:0] b);
    case (b)
      BU_WRAP4: return 3'd2;
      BU_WRAP8: return 3'd3;
      default:  return 3'd4;
    endcase
  endfunction

  function automatic int unsigned burst_beats(input logic [2:0] b, input int unsigned len);
    case (b)
      BU_SINGLE:           return 1;
      BU_INCR:             return (len == 0) ? 1 : len;
      BU_WRAP4, BU_INCR4:  return 4;
      BU_WRAP8, BU_INCR8:  return 8;
      default:             return 16;
    endcase
  endfunction

endpackage

// File: rtl/agen_addr_step.sv
module agen_addr_step
  import ahb_agen_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BOUND_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [2:0]        size_i,
  input  logic [2:0]        burst_i,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic              at_bound_o
);
  localparam int BOUND_W = $clog2(BOUND_BYTES);

  // next beat address: plain increment, or increment kept inside the wrap window
  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                             input logic [2:0] sz,
                                             input logic [2:0] bu);
    logic [ADDR_W-1:0] nb, inc, span, msk;
    nb  = ADDR_W'(1) << sz;
    inc = a + nb;
    if (is_wrap(bu)) begin
      span = nb << wrap_shift(bu);
      msk  = span - ADDR_W'(1);
      return (a & ~msk) | (inc & msk);
    end
    return inc;
  endfunction

  assign nxt_addr_o = step(cur_addr_i, size_i, burst_i);
  assign at_bound_o = (nxt_addr_o[BOUND_W-1:0] == '0);

endmodule

// File: rtl/agen_beat_track.sv
module agen_beat_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             accept_i,
  input  logic             hready_i,
  input  logic             abort_i,
  output logic             last_beat_o,
  output logic             dphase_o,
  output logic             finish_o,
  output logic             done_o
);
  logic [CNT_W-1:0] left_q;
  logic             dphase_q;
  logic             lastdp_q;
  logic             done_q;

  assign last_beat_o = (left_q == CNT_W'(1));
  assign finish_o    = lastdp_q && hready_i && !abort_i;
  assign dphase_o    = dphase_q;
  assign done_o      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      dphase_q <= 1'b0;
      lastdp_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish_o;
      if (abort_i) begin
        left_q   <= '0;
        dphase_q <= 1'b0;
        lastdp_q <= 1'b0;
      end else begin
        if (load_i)        left_q <= load_cnt_i;
        else if (accept_i) left_q <= left_q - CNT_W'(1);
        if (accept_i) begin
          dphase_q <= 1'b1;
          lastdp_q <= last_beat_o;
        end else if (hready_i) begin
          dphase_q <= 1'b0;
          lastdp_q <= 1'b0;
        end
      end
    end
  end

  // R10: done is a single-cycle pulse
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: a data phase waits while HREADY is low
  a_r6_dphase_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (dphase_q && !hready_i && !abort_i) |=> dphase_q);

endmodule

// File: rtl/ahb_burst_agen.sv
module ahb_burst_agen
  import ahb_agen_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 8,
  parameter int BOUND_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        start_size_i,
  input  logic [2:0]        start_burst_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic              start_write_i,
  input  logic              busy_req_i,
  input  logic              hready_i,
  input  logic              hresp_i,
  output logic [ADDR_W-1:0] haddr_o,
  output logic [1:0]        htrans_o,
  output logic [2:0]        hsize_o,
  output logic [2:0]        hburst_o,
  output logic              hwrite_o,
  output logic              active_o,
  output logic              done_o
);
  localparam int         MAX_SIZE = $clog2(DATA_W / 8);
  localparam logic [2:0] MAX_SZ   = 3'(MAX_SIZE);
  localparam int         CNT_W    = (LEN_W > 5) ? LEN_W : 5;
  localparam int         BOUND_W  = $clog2(BOUND_BYTES);

  logic [ADDR_W-1:0] haddr_q;
  htrans_e           htrans_q;
  logic [2:0]        hsize_q;
  logic [2:0]        hburst_q;
  logic              hwrite_q;
  logic              active_q;
  logic              restart_q;

  // named internal events
  logic [ADDR_W-1:0] nxt_addr;
  logic              at_bound;
  logic              beat_live;
  logic              beat_acc;
  logic              err_hit;
  logic              start_ok;
  logic              nonseq_next;
  logic              last_beat;
  logic              dphase;
  logic              finish;
  logic [2:0]        size_clamp;
  logic [CNT_W-1:0]  load_cnt;

  assign beat_live   = (htrans_q == TR_NONSEQ) || (htrans_q == TR_SEQ);
  assign err_hit     = dphase && hresp_i;
  assign beat_acc    = beat_live && hready_i && !err_hit;
  assign start_ok    = start_i && !active_q;
  assign nonseq_next = (hburst_q == BU_INCR) && at_bound;
  assign size_clamp  = (start_size_i > MAX_SZ) ? MAX_SZ : start_size_i;
  assign load_cnt    = CNT_W'(burst_beats(start_burst_i, 32'(start_len_i)));

  agen_addr_step #(
    .ADDR_W      (ADDR_W),
    .BOUND_BYTES (BOUND_BYTES)
  ) u_step (
    .cur_addr_i (haddr_q),
    .size_i     (hsize_q),
    .burst_i    (hburst_q),
    .nxt_addr_o (nxt_addr),
    .at_bound_o (at_bound)
  );

  agen_beat_track #(
    .CNT_W (CNT_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (start_ok),
    .load_cnt_i  (load_cnt),
    .accept_i    (beat_acc),
    .hready_i    (hready_i),
    .abort_i     (err_hit),
    .last_beat_o (last_beat),
    .dphase_o    (dphase),
    .finish_o    (finish),
    .done_o      (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr_q   <= '0;
      htrans_q  <= TR_IDLE;
      hsize_q   <= '0;
      hburst_q  <= BU_SINGLE;
      hwrite_q  <= 1'b0;
      active_q  <= 1'b0;
      restart_q <= 1'b0;
    end else if (err_hit) begin
      htrans_q <= TR_IDLE;
      active_q <= 1'b0;
    end else begin
      if (finish) active_q <= 1'b0;
      if (start_ok) begin
        haddr_q   <= start_addr_i;
        hsize_q   <= size_clamp;
        hburst_q  <= start_burst_i;
        hwrite_q  <= start_write_i;
        htrans_q  <= TR_NONSEQ;
        active_q  <= 1'b1;
        restart_q <= 1'b0;
      end else if (hready_i) begin
        case (htrans_q)
          TR_NONSEQ, TR_SEQ: begin
            if (last_beat) begin
              htrans_q <= TR_IDLE;
            end else begin
              haddr_q   <= nxt_addr;
              restart_q <= nonseq_next;
              if (busy_req_i)       htrans_q <= TR_BUSY;
              else if (nonseq_next) htrans_q <= TR_NONSEQ;
              else                  htrans_q <= TR_SEQ;
            end
          end
          TR_BUSY: begin
            if (!busy_req_i) htrans_q <= restart_q ? TR_NONSEQ : TR_SEQ;
          end
          default: ;
        endcase
      end
    end
  end

  assign haddr_o  = haddr_q;
  assign htrans_o = htrans_q;
  assign hsize_o  = hsize_q;
  assign hburst_o = hburst_q;
  assign hwrite_o = hwrite_q;
  assign active_o = active_q;

  // R1: nothing but IDLE while no burst runs
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (htrans_q == TR_IDLE));

  // R2: an accepted start shows NONSEQ at the start address
  a_r2_start_nonseq: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !active_o) |=> (htrans_o == 2'b10 && haddr_o == $past(start_addr_i)));

  // R3: SEQ never follows IDLE
  a_r3_seq_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == TR_SEQ) |-> ($past(htrans_q) != TR_IDLE));

  // R5: size within the bus width and constant through a burst
  a_r5_size_limit: assert property (@(posedge clk) disable iff (!rst_n)
    hsize_o <= MAX_SZ);
  a_r5_size_const: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> (!active_q || $stable(hsize_o)));

  // R6: address and control held through a wait state
  a_r6_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q != TR_IDLE && !hready_i && !err_hit) |=>
      ($stable(haddr_o) && $stable(htrans_o) && $stable(hburst_o) && $stable(hwrite_o)));

  // R8: an open-ended burst never continues with SEQ onto a 1 KB boundary
  a_r8_incr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == TR_SEQ && hburst_q == BU_INCR) |-> (haddr_q[BOUND_W-1:0] != '0));

  // R9: error response drops the burst
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |=> (htrans_o == 2'b00 && !active_o && !done_o));

  // R10: done only after the burst has ended
  a_r10_done_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active_o);

endmodule

// File: tb/ahb_burst_agen_tb_top.sv
`timescale 1ns/1ps
module ahb_burst_agen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [2:0]  start_size_i = '0;
  logic [2:0]  start_burst_i = '0;
  logic [7:0]  start_len_i = '0;
  logic        start_write_i = 1'b0;
  logic        busy_req_i = 1'b0;
  logic        hready_i = 1'b1;
  logic        hresp_i = 1'b0;
  logic [31:0] haddr_o;
  logic [1:0]  htrans_o;
  logic [2:0]  hsize_o;
  logic [2:0]  hburst_o;
  logic        hwrite_o;
  logic        active_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ahb_burst_agen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .start_size_i(start_size_i), .start_burst_i(start_burst_i), .start_len_i(start_len_i),
    .start_write_i(start_write_i), .busy_req_i(busy_req_i), .hready_i(hready_i),
    .hresp_i(hresp_i), .haddr_o(haddr_o), .htrans_o(htrans_o), .hsize_o(hsize_o),
    .hburst_o(hburst_o), .hwrite_o(hwrite_o), .active_o(active_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned n_beats(input logic [2:0] bu, input int unsigned len);
    case (bu)
      3'd0: return 1;
      3'd1: return (len == 0) ? 1 : len;
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic bit wrapping(input logic [2:0] bu);
    return (bu == 3'd2) || (bu == 3'd4) || (bu == 3'd6);
  endfunction

  // address of beat k, restated as base plus offset modulo the window
  function automatic logic [31:0] exp_addr(input logic [31:0] a0, input int unsigned esz,
                                           input logic [2:0] bu, input int unsigned n, input int unsigned k);
    int unsigned bytes, span;
    logic [31:0] base;
    bytes = 1 << esz;
    if (wrapping(bu)) begin
      span = bytes * n;
      base = a0 - (a0 % span);
      return base + (((a0 - base) + k * bytes) % span);
    end
    return a0 + k * bytes;
  endfunction

  task automatic run_burst(input logic [31:0] a0, input logic [2:0] sz, input logic [2:0] bu,
                           input int unsigned len, input bit wr, input bit allow_busy, input int hr_pct);
    int unsigned n, esz, k, cyc;
    logic [1:0]  exp_tr, new_tr, prev_tr;
    logic [31:0] prev_addr;
    bit exp_done, dp, dp_last, finished, hr, bz, prev_hr, nd;
    string rq;
    esz = (sz > 3'd2) ? 2 : int'(sz);
    n   = n_beats(bu, len);
    while (active_o) @(negedge clk);
    start_i = 1'b1; start_addr_i = a0; start_size_i = sz; start_burst_i = bu;
    start_len_i = 8'(len); start_write_i = wr; hready_i = 1'b1; busy_req_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "hwrite", 32'(hwrite_o), 32'(wr));
    k = 0; exp_tr = 2'b10; exp_done = 0; dp = 0; dp_last = 0; finished = 0; cyc = 0;
    prev_hr = 1; prev_tr = 2'b00; prev_addr = '0;
    while (!finished && cyc < 3000) begin
      cyc++;
      if (!prev_hr && prev_tr != 2'b00) begin
        chk("R6", "held htrans", 32'(htrans_o), 32'(prev_tr));
        chk("R6", "held haddr", haddr_o, prev_addr);
      end
      if (k == 0) rq = "R2";
      else if (exp_tr == 2'b01) rq = "R7";
      else if (exp_tr == 2'b10) rq = "R8";
      else rq = "R3";
      chk(rq, "htrans", 32'(htrans_o), 32'(exp_tr));
      if (exp_tr != 2'b00) begin
        chk(wrapping(bu) ? "R4" : rq, "haddr", haddr_o, exp_addr(a0, esz, bu, n, k));
        chk("R5", "hsize", 32'(hsize_o), 32'(esz));
        chk("R2", "hburst", 32'(hburst_o), 32'(bu));
      end
      chk("R10", "done", 32'(done_o), 32'(exp_done));
      if (exp_done) begin
        chk("R10", "active after done", 32'(active_o), 32'd0);
        chk("R1", "idle after burst", 32'(htrans_o), 32'd0);
        finished = 1;
        start_i = 1'b0;
      end else begin
        chk("R2", "burst stays active", 32'(active_o), 32'd1);
        hr = ($urandom % 100) < hr_pct;
        bz = allow_busy && (($urandom % 4) == 0);
        hready_i = hr; busy_req_i = bz;
        start_i = (($urandom % 8) == 0);
        start_addr_i = $urandom; start_burst_i = 3'($urandom); start_size_i = 3'($urandom);
        nd = 0;
        if (dp && hr) begin nd = dp_last; dp = 0; dp_last = 0; end
        new_tr = exp_tr;
        if (hr) begin
          if (exp_tr == 2'b10 || exp_tr == 2'b11) begin
            k++; dp = 1; dp_last = (k == n);
            if (k == n) new_tr = 2'b00;
            else if (bz) new_tr = 2'b01;
            else new_tr = (bu == 3'd1 && exp_addr(a0, esz, bu, n, k) % 1024 == 0) ? 2'b10 : 2'b11;
          end else if (exp_tr == 2'b01 && !bz) begin
            new_tr = (bu == 3'd1 && exp_addr(a0, esz, bu, n, k) % 1024 == 0) ? 2'b10 : 2'b11;
          end
        end
        prev_hr = hr; prev_tr = htrans_o; prev_addr = haddr_o;
        exp_done = nd; exp_tr = new_tr;
        @(negedge clk);
      end
    end
    if (!finished) chk("R10", "burst never finished", 32'd0, 32'd1);
    hready_i = 1'b1; busy_req_i = 1'b0; start_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk("R1", "reset htrans", 32'(htrans_o), 32'd0);
    chk("R1", "reset active", 32'(active_o), 32'd0);
    chk("R1", "reset done", 32'(done_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle htrans", 32'(htrans_o), 32'd0);

    // directed corner cases
    run_burst(32'h34, 3'd2, 3'd2, 0, 1'b1, 1'b0, 100);   // R4 example wrap
    run_burst(32'h3F8, 3'd2, 3'd1, 4, 1'b0, 1'b0, 100);  // R8 crossing
    run_burst(32'h7F0, 3'd3, 3'd1, 8, 1'b0, 1'b1, 60);   // R5 clamp, R8 with BUSY
    run_burst(32'h100, 3'd0, 3'd0, 0, 1'b1, 1'b0, 50);   // single, R10
    run_burst(32'h3C, 3'd1, 3'd6, 0, 1'b0, 1'b1, 70);    // R4 wrap16 halfwords
    run_burst(32'h10, 3'd2, 3'd1, 0, 1'b0, 1'b0, 100);   // len 0 counts as 1

    // R9 error response mid-burst
    while (active_o) @(negedge clk);
    start_i = 1'b1; start_addr_i = 32'h200; start_size_i = 3'd2; start_burst_i = 3'd3;
    hready_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    chk("R9", "second beat before error", 32'(htrans_o), 32'd3);
    hready_i = 1'b0; hresp_i = 1'b1;
    @(negedge clk);
    chk("R9", "htrans after error", 32'(htrans_o), 32'd0);
    chk("R9", "active after error", 32'(active_o), 32'd0);
    hready_i = 1'b1;
    @(negedge clk);
    hresp_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R9", "no done after error", 32'(done_o), 32'd0);
      chk("R9", "stays idle", 32'(htrans_o), 32'd0);
      @(negedge clk);
    end

    // constrained random bursts
    for (int t = 0; t < 70; t++) begin
      logic [2:0] sz, bu;
      int unsigned esz, bytes, n, len;
      logic [31:0] a0;
      sz = 3'($urandom % 4); bu = 3'($urandom % 8); len = 1 + $urandom % 20;
      esz = (sz > 3'd2) ? 2 : int'(sz); bytes = 1 << esz; n = n_beats(bu, len);
      a0 = ($urandom & 32'h0000_FFFF) & ~(bytes - 1);
      if (bu == 3'd1 && ($urandom % 3) == 0)
        a0 = (a0 & ~32'h3FF) + 1024 - bytes * (1 + $urandom % 4);
      if (!wrapping(bu) && bu != 3'd1 && ((a0 % 1024) + n * bytes > 1024))
        a0 = a0 - n * bytes;
      run_burst(a0, sz, bu, len, 1'($urandom), 1'b1, 50 + int'($urandom % 50));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule